// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block is a SIMD integer datapath for inference-style multiply-accumulate work. Each 32-bit lane of the destination vector is a signed accumulator. The block adds to it the sum of several element products taken from the same lane of two source vectors. There are two element shapes. Byte mode multiplies unsigned bytes by signed bytes, four products per lane. Word mode multiplies signed halfwords by signed halfwords, two products per lane. Either shape can wrap modulo 2^32 or clamp to the signed 32-bit range.

The vector is built from 128-bit segments of four lanes each. A length select enables one, two or all four segments. A 16-bit write mask merges the new lane values with the incoming accumulator. The result is captured in one register stage when the input strobe is high, and a valid flag is raised alongside it.

Top module: `dot_acc_top`

## Requirements
- R1: With op_i = 0, each enabled lane gets the accumulator plus the sum of four products. Each product is an unsigned byte of src_a_i times the signed byte at the same position in src_b_i. The result wraps modulo 2^32.
- R2: With op_i = 1, the lane value is the same sum as in R1, formed without overflow. It is clamped to the range 0x80000000 to 0x7FFFFFFF.
- R3: With op_i = 2, each enabled lane gets the accumulator plus two signed 16x16 products of matching halfwords, wrapping modulo 2^32. The pair sum is formed wide enough that two products of -32768 x -32768 do not overflow before the accumulate.
- R4: With op_i = 3, the lane value is the same sum as in R3, formed without overflow and clamped to the signed 32-bit range.
- R5: vlen_i selects the active lanes. A value of 0 enables lanes 0-3, 1 enables lanes 0-7, and 2 or 3 enables all 16 lanes. Lane l occupies bits [32l+31:32l]. Inactive lanes output zero, whatever the mask says.
- R6: When mask_en_i is high, an active lane l whose mask_i[l] is 0 outputs its acc_i lane unchanged.
- R7: When mask_en_i is low, every active lane is written, whatever the value of mask_i.
- R8: result_o and valid_o are updated on the clock edge that samples valid_i high, so the latency is one cycle. valid_o is low in every cycle after one in which valid_i was low. Back-to-back inputs give back-to-back results.
- R9: While valid_i is low, result_o holds its last value, even if the data inputs change.
- R10: During reset (rst_ni low), valid_o is 0 and result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input strobe; capture the computed vector |
| op_i | input | 2 | 0 byte wrap, 1 byte saturate, 2 word wrap, 3 word saturate |
| vlen_i | input | 2 | Active length: 0 = 128, 1 = 256, 2 or 3 = 512 bits |
| mask_en_i | input | 1 | 1 = apply mask_i, 0 = write all lanes |
| mask_i | input | 16 | Per-lane write enable, bit l for lane l |
| acc_i | input | 512 | Accumulator / prior destination vector |
| src_a_i | input | 512 | First source (unsigned bytes or signed halfwords) |
| src_b_i | input | 512 | Second source (signed bytes or signed halfwords) |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 512 | Updated destination vector |

## Verification
Length zeroing and merge masking act on the same lane in the same cycle. The bench provokes this by clearing mask bits above the selected length with a nonzero accumulator, and it expects zeros there rather than the accumulator. Saturation and masking also meet on one vector. A saturating corner sits in enabled lanes next to mask-off lanes, and each lane is judged against the bench's own model value. Back-to-back strobes with changing operations check that the scoreboard order matches the one-cycle latency.

// File: rtl/dot_acc_pkg.sv
package dot_acc_pkg;
  localparam int LANE_W    = 32;
  localparam int SEG_W     = 128;
  localparam int SEG_LANES = SEG_W / LANE_W;
  localparam int ACC_W     = 64;  // accumulate width, covers any lane sum

  typedef enum logic [1:0] {
    OP_BYTE_WRAP = 2'd0,
    OP_BYTE_SAT  = 2'd1,
    OP_WORD_WRAP = 2'd2,
    OP_WORD_SAT  = 2'd3
  } dp_op_e;
endpackage

// File: rtl/dot_acc_sat.sv
module dot_acc_sat #(
  parameter int IN_W  = 64,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  val_i,
  input  logic                    sat_en_i,
  output logic        [OUT_W-1:0] val_o
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (sat_en_i && (val_i > HI))      val_o = HI[OUT_W-1:0];
    else if (sat_en_i && (val_i < LO)) val_o = LO[OUT_W-1:0];
    else                               val_o = val_i[OUT_W-1:0];
  end
endmodule

// File: rtl/dot_acc_lane.sv
module dot_acc_lane
  import dot_acc_pkg::*;
(
  input  dp_op_e             op_i,
  input  logic [LANE_W-1:0]  acc_i,
  input  logic [LANE_W-1:0]  a_i,
  input  logic [LANE_W-1:0]  b_i,
  output logic [LANE_W-1:0]  res_o
);
  localparam int NB = LANE_W / 8;
  localparam int NW = LANE_W / 16;

  logic signed [16:0]      bprod [NB];
  logic signed [31:0]      wprod [NW];
  logic signed [ACC_W-1:0] dot, total;
  logic                    word_mode;

  assign word_mode = op_i[1];

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic signed [8:0] ua;
    logic signed [7:0] sb;
    assign ua = {1'b0, a_i[8*k +: 8]};
    assign sb = b_i[8*k +: 8];
    assign bprod[k] = 17'(ua) * 17'(sb);
  end

  for (genvar k = 0; k < NW; k++) begin : g_word
    logic signed [15:0] wa, wb;
    assign wa = a_i[16*k +: 16];
    assign wb = b_i[16*k +: 16];
    assign wprod[k] = 32'(wa) * 32'(wb);
  end

  // products widened before summing so the word pair cannot overflow
  always_comb begin
    dot = '0;
    if (word_mode) begin
      for (int k = 0; k < NW; k++) dot = dot + ACC_W'(wprod[k]);
    end else begin
      for (int k = 0; k < NB; k++) dot = dot + ACC_W'(bprod[k]);
    end
    total = ACC_W'($signed(acc_i)) + dot;
  end

  dot_acc_sat #(.IN_W(ACC_W), .OUT_W(LANE_W)) u_sat (
    .val_i    (total),
    .sat_en_i (op_i[0]),
    .val_o    (res_o)
  );
endmodule

// File: rtl/dot_acc_top.sv
module dot_acc_top
  import dot_acc_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic [15:0]      mask_i,
  input  logic [VEC_W-1:0] acc_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] result_o
);
  localparam int NUM_LANES = VEC_W / LANE_W;
  localparam int NUM_SEGS  = VEC_W / SEG_W;
  localparam int SEG_CW    = $clog2(NUM_SEGS + 1);
  localparam int SEG2      = (NUM_SEGS < 2) ? NUM_SEGS : 2;

  dp_op_e             op;
  logic [SEG_CW-1:0]  seg_cnt;
  logic [VEC_W-1:0]   next_vec;
  logic               armed;

  assign op = dp_op_e'(op_i);

  always_comb begin
    case (vlen_i)
      2'd0:    seg_cnt = SEG_CW'(1);
      2'd1:    seg_cnt = SEG_CW'(SEG2);
      default: seg_cnt = SEG_CW'(NUM_SEGS);
    endcase
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_res;
    logic              lane_on, wr_en;

    dot_acc_lane u_lane (
      .op_i  (op),
      .acc_i (acc_i[LANE_W*l +: LANE_W]),
      .a_i   (src_a_i[LANE_W*l +: LANE_W]),
      .b_i   (src_b_i[LANE_W*l +: LANE_W]),
      .res_o (lane_res)
    );

    assign lane_on = SEG_CW'(l / SEG_LANES) < seg_cnt;
    assign wr_en   = !mask_en_i || mask_i[l % 16];
    assign next_vec[LANE_W*l +: LANE_W] = !lane_on ? '0 :
                                          wr_en    ? lane_res :
                                                     acc_i[LANE_W*l +: LANE_W];

    // R5
    tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && ((vlen_i == 2'd0 && l >= 4) || (vlen_i == 2'd1 && l >= 8))
      |=> result_o[LANE_W*l +: LANE_W] == '0);

    // R6
    mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i && mask_en_i && !mask_i[l % 16] &&
      !((vlen_i == 2'd0 && l >= 4) || (vlen_i == 2'd1 && l >= 8))
      |=> result_o[LANE_W*l +: LANE_W] == $past(acc_i[LANE_W*l +: LANE_W]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      armed    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      armed   <= 1'b1;
      if (valid_i) result_o <= next_vec;
    end
  end

  // R8
  lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> valid_o == $past(valid_i));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !valid_i |=> $stable(result_o));
endmodule

// File: tb/dot_acc_top_test.sv
`timescale 1ns/1ps
module dot_acc_top_test;
  localparam int VW = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [1:0]    vlen_i = '0;
  logic          mask_en_i = 1'b0;
  logic [15:0]   mask_i = '0;
  logic [VW-1:0] acc_i = '0, src_a_i = '0, src_b_i = '0;
  logic          valid_o;
  logic [VW-1:0] result_o;

  int checks = 0;
  int errors = 0;
  logic [VW-1:0] last_exp = '0;

  typedef struct {
    logic [VW-1:0] exp;
    string         tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #2 clk_i = ~clk_i;

  dot_acc_top uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .vlen_i, .mask_en_i, .mask_i,
    .acc_i, .src_a_i, .src_b_i, .valid_o, .result_o
  );

  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [1:0] vl,
      input logic men, input logic [15:0] msk,
      input logic [VW-1:0] acc, input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [VW-1:0] r;
    int act;
    act = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    r = '0;
    for (int l = 0; l < 16; l++) begin
      longint s, t;
      if (l >= act) r[32*l +: 32] = '0;
      else if (men && !msk[l]) r[32*l +: 32] = acc[32*l +: 32];
      else begin
        s = 0;
        if (!op[1]) begin
          for (int k = 0; k < 4; k++)
            s += longint'({1'b0, a[32*l+8*k +: 8]}) * longint'($signed(b[32*l+8*k +: 8]));
        end else begin
          for (int k = 0; k < 2; k++)
            s += longint'($signed(a[32*l+16*k +: 16])) * longint'($signed(b[32*l+16*k +: 16]));
        end
        t = longint'($signed(acc[32*l +: 32])) + s;
        if (op[0]) begin
          if (t > 64'sd2147483647) t = 64'sd2147483647;
          else if (t < -64'sd2147483648) t = -64'sd2147483648;
        end
        r[32*l +: 32] = t[31:0];
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW / 32; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [1:0] vl, input logic men,
      input logic [15:0] msk, input logic [VW-1:0] acc, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input string tag);
    sb_item_t it;
    @(negedge clk_i);
    op_i = op; vlen_i = vl; mask_en_i = men; mask_i = msk;
    acc_i = acc; src_a_i = a; src_b_i = b; valid_i = 1'b1;
    it.exp = model(op, vl, men, msk, acc, a, b);
    it.tag = tag;
    last_exp = it.exp;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sbq.size() == 0) chk(1'b0, "R8 unexpected valid_o", result_o, '0);
      else begin
        sb_item_t it;
        it = sbq.pop_front();
        chk(result_o === it.exp, it.tag, result_o, it.exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [VW-1:0] ones_b, neg_b, pos_b, min_w, x, y, z;
    ones_b = {VW/8{8'hFF}};
    neg_b  = {VW/8{8'h80}};
    pos_b  = {VW/8{8'h7F}};
    min_w  = {VW/16{16'h8000}};

    repeat (2) @(negedge clk_i);
    // R10
    chk(valid_o === 1'b0 && result_o === '0, "R10 reset state", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R10 idle after reset", {511'b0, valid_o}, '0);

    // R1 byte wrap
    send(2'd0, 2'd2, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R1 byte wrap random");
    send(2'd0, 2'd2, 1'b0, 16'h0000, {16{32'h80000000}}, ones_b, neg_b, "R1 byte wrap underflow");
    // R2 byte saturate
    send(2'd1, 2'd2, 1'b0, 16'h0000, {16{32'h80000000}}, ones_b, neg_b, "R2 byte sat min clamp");
    send(2'd1, 2'd2, 1'b0, 16'h0000, {16{32'h7FFFFFF0}}, ones_b, pos_b, "R2 byte sat max clamp");
    send(2'd1, 2'd3, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R2 byte sat random");
    // R3 word wrap
    send(2'd2, 2'd2, 1'b0, 16'h0000, '0, min_w, min_w, "R3 word wrap min*min pair");
    send(2'd2, 2'd2, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R3 word wrap random");
    // R4 word saturate
    send(2'd3, 2'd2, 1'b0, 16'h0000, '0, min_w, min_w, "R4 word sat min*min pair");
    send(2'd3, 2'd2, 1'b0, 16'h0000, {16{32'h80000001}}, min_w, {VW/16{16'h7FFF}}, "R4 word sat low clamp");
    send(2'd3, 2'd2, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R4 word sat random");
    idle(2);

    // R5 lengths, with mask clear above length (zero wins)
    send(2'd0, 2'd0, 1'b1, 16'h000F, rnd_vec(), rnd_vec(), rnd_vec(), "R5 vlen 128 mask off tail");
    send(2'd2, 2'd1, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R5 vlen 256");
    send(2'd1, 2'd3, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R5 vlen code 3 full");
    // R6 mask merge, with saturation in enabled lanes
    send(2'd1, 2'd2, 1'b1, 16'hA5A5, {16{32'h7FFFFFF0}}, ones_b, pos_b, "R6 mask merge sat");
    send(2'd3, 2'd1, 1'b1, 16'h3C00, rnd_vec(), rnd_vec(), rnd_vec(), "R6 mask merge word");
    // R7 mask ignored when disabled
    send(2'd0, 2'd2, 1'b0, 16'h0000, rnd_vec(), rnd_vec(), rnd_vec(), "R7 mask_en low");
    idle(1);
    // R8 valid_o low after idle cycle
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R8 valid_o low when idle", {511'b0, valid_o}, '0);

    // R9 hold while idle with changing inputs
    x = rnd_vec(); y = rnd_vec(); z = rnd_vec();
    send(2'd2, 2'd2, 1'b0, 16'h0000, x, y, z, "R9 load before hold");
    @(negedge clk_i);
    valid_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      acc_i = rnd_vec(); src_a_i = rnd_vec(); src_b_i = rnd_vec(); op_i = 2'(i);
      @(negedge clk_i);
      chk(result_o === last_exp, "R9 hold while idle", result_o, last_exp);
    end

    // R8 back-to-back with changing ops
    for (int i = 0; i < 8; i++)
      send(2'(i), 2'(i), 1'(i % 2), 16'($urandom), rnd_vec(), rnd_vec(), rnd_vec(), "R8 back-to-back");
    idle(3);
    chk(sbq.size() == 0, "R8 all results delivered", VW'(sbq.size()), '0);
    summary();
  end
endmodule